// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the network stage of a 1-Wire slave. It sits between a bit-level engine, which recovers reset pulses and time slots from the wire, and a memory command controller. After every bus reset it receives an 8-bit ROM command and runs it: it reports the 64-bit registration number, compares it against a number the master sends, or takes part in a bitwise search. When the device is selected, it passes the bus to the memory controller. It also keeps a resume flag for fast reselection and a speed flag that the bit engine uses to switch to overdrive timing.

The registration number is built from two parameters, a family byte and a 48-bit serial number. Its CRC-8 byte is not stored. A serial CRC engine derives it during the first cycles after the chip reset, and bus resets are ignored until it is ready. The bit engine reports each time slot as a one-cycle `slot_i` pulse together with the bit the master left on the wire. For slots in which this layer transmits, `tx_en_o` and `tx_bit_o` hold the value the engine should drive in the coming slot.

Top module: `owrom_net_layer`

## Requirements
- R1: After the chip reset, `od_o`, `rc_o`, `mem_own_o`, `mem_sel_o` and `tx_en_o` are all 0, and `tx_bit_o` is 1 (released).
- R2: Command 33h (read ROM) clears the resume flag. It then transmits 64 bits, least significant bit first: the family byte (default 23h), the 48-bit serial number, and a CRC-8 of those 56 bits. The CRC uses x^8+x^5+x^4+1, starts from zero and is processed LSB first. After the 64th slot it selects the device.
- R3: Command 55h (match ROM) clears the resume flag and then compares 64 received bits with the registration number. If all 64 agree, it sets the resume flag and selects the device in the cycle after the last slot.
- R4: If any received bit differs during match ROM, the device is not selected. It drives nothing and forwards nothing until the next bus reset.
- R5: Command F0h (search ROM) clears the resume flag and runs 64 triplets of slots. In each triplet it drives the true bit, then the complemented bit, then reads the master's bit. A full pass with no disagreement sets the resume flag and selects the device.
- R6: When the master's bit in a search triplet differs from the device's bit, the device stops driving the bus until the next bus reset.
- R7: Command CCh (skip ROM) clears the resume flag and selects the device straight after the command byte.
- R8: Command A5h (resume) selects the device only while the resume flag is 1. Otherwise the device ignores the bus until reset. Resume leaves the flag unchanged.
- R9: Command 3Ch (overdrive skip) clears the resume flag, sets `od_o` and selects the device.
- R10: Command 69h (overdrive match) clears the resume flag and sets `od_o` after the command byte, then matches 64 bits. On success it sets the resume flag and selects the device. On a mismatch it clears `od_o`, unless `od_o` was already 1 before the command.
- R11: A bus reset with `rst_long_i`=1 clears `od_o`. A bus reset with `rst_long_i`=0 leaves it unchanged.
- R12: Any other command byte leaves the resume flag unchanged and makes the device ignore the bus until the next bus reset.
- R13: Selection raises `mem_sel_o` for exactly one cycle and sets `mem_own_o`. While `mem_own_o` is 1, `mem_slot_o` follows `slot_i` and `mem_bit_o` follows `slot_bit_i`. Every bus reset clears `mem_own_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous chip reset |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset detected |
| rst_long_i | input | 1 | Qualifies bus_rst_i as a standard-speed (long) reset |
| slot_i | input | 1 | One-cycle pulse: a time slot completed |
| slot_bit_i | input | 1 | Bit seen on the wire in that slot |
| tx_en_o | output | 1 | This layer drives the next slot |
| tx_bit_o | output | 1 | Bit to drive in the next slot (1 when released) |
| od_o | output | 1 | Overdrive speed flag |
| rc_o | output | 1 | Resume flag |
| mem_sel_o | output | 1 | One-cycle select strobe to the memory controller |
| mem_own_o | output | 1 | Memory controller owns the bus |
| mem_slot_o | output | 1 | Slot pulse forwarded to the memory controller |
| mem_bit_o | output | 1 | Slot bit forwarded to the memory controller |

## Verification
Every state change is registered on the clock edge that sees `slot_i` or `bus_rst_i`. The flags, the select strobe and the next transmit bit are therefore due one edge after the stimulus. The bench raises each pulse for one cycle starting at a falling edge and samples at the following falling edge, which is where `mem_sel_o` is checked before it drops one edge later. `mem_slot_o` is combinational and is sampled inside the pulse, a quarter period after it is raised. Transmit bits are compared before the slot that consumes them. The bench waits out the CRC start-up interval before the first bus reset.

// File: rtl/owrom_pkg.sv
package owrom_pkg;
  typedef enum logic [2:0] {
    ST_WAIT, ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_MEM, ST_SINK
  } net_st_e;

  localparam logic [7:0] CMD_READ   = 8'h33;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_SEARCH = 8'hF0;
  localparam logic [7:0] CMD_SKIP   = 8'hCC;
  localparam logic [7:0] CMD_RESUME = 8'hA5;
  localparam logic [7:0] CMD_ODSKIP = 8'h3C;
  localparam logic [7:0] CMD_ODMTCH = 8'h69;
endpackage

// File: rtl/owrom_crc8.sv
module owrom_crc8 #(
  parameter int          CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic fb;
  assign fb = crc_o[0] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_o <= '0;
    else if (en_i) crc_o <= (crc_o >> 1) ^ (fb ? POLY_REFL : '0);
  end
endmodule

// File: rtl/owrom_id.sv
module owrom_id #(
  parameter logic [7:0]  FAMILY = 8'h23,
  parameter logic [47:0] SERIAL = 48'h0,
  parameter int          ID_W   = 64,
  parameter int          CRC_W  = 8,
  localparam int         IDX_W  = $clog2(ID_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o,
  output logic             ready_o
);
  localparam int DATA_W = ID_W - CRC_W;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] body;
  logic [CNT_W-1:0]  cnt;
  logic [CRC_W-1:0]  crc;
  logic [ID_W-1:0]   full;
  logic              run;

  assign body    = {SERIAL, FAMILY};
  assign run     = (cnt != CNT_W'(DATA_W));
  assign ready_o = !run;
  assign full    = {crc, body};
  assign bit_o   = full[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end

  owrom_crc8 #(.CRC_W(CRC_W)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .bit_i  (run ? body[cnt[$clog2(DATA_W)-1:0]] : 1'b0),
    .crc_o  (crc)
  );

  AST_ID_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R2
  AST_CRC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> $stable(crc)); // R2
endmodule

// File: rtl/owrom_net_layer.sv
module owrom_net_layer
  import owrom_pkg::*;
#(
  parameter logic [7:0]  FAMILY = 8'h23,
  parameter logic [47:0] SERIAL = 48'h00A1B2C3D4E5,
  parameter int          ID_W   = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_i,
  input  logic rst_long_i,
  input  logic slot_i,
  input  logic slot_bit_i,
  output logic tx_en_o,
  output logic tx_bit_o,
  output logic od_o,
  output logic rc_o,
  output logic mem_sel_o,
  output logic mem_own_o,
  output logic mem_slot_o,
  output logic mem_bit_o
);
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

  net_st_e          st;
  logic [IDX_W-1:0] idx;
  logic [1:0]       ph;
  logic [2:0]       bcnt;
  logic [6:0]       cmd_sr;
  logic [7:0]       cmd_w;
  logic             od_prev, od_mtch;
  logic             id_bit, id_ready, last;

  owrom_id #(.FAMILY(FAMILY), .SERIAL(SERIAL), .ID_W(ID_W)) u_id (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (idx),
    .bit_o   (id_bit),
    .ready_o (id_ready)
  );

  assign cmd_w = {slot_bit_i, cmd_sr};
  assign last  = (idx == IDX_LAST);

  always_comb begin
    tx_en_o  = (st == ST_READ) || (st == ST_SEARCH && ph != 2'd2);
    tx_bit_o = 1'b1;
    if (tx_en_o) tx_bit_o = (st == ST_SEARCH && ph == 2'd1) ? !id_bit : id_bit;
  end

  assign mem_own_o  = (st == ST_MEM);
  assign mem_slot_o = slot_i & mem_own_o;
  assign mem_bit_o  = slot_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_WAIT;
      idx       <= '0;
      ph        <= '0;
      bcnt      <= '0;
      cmd_sr    <= '0;
      od_o      <= 1'b0;
      rc_o      <= 1'b0;
      od_prev   <= 1'b0;
      od_mtch   <= 1'b0;
      mem_sel_o <= 1'b0;
    end else begin
      mem_sel_o <= 1'b0;
      if (bus_rst_i && id_ready) begin
        st      <= ST_CMD;
        idx     <= '0;
        ph      <= '0;
        bcnt    <= '0;
        od_mtch <= 1'b0;
        if (rst_long_i) od_o <= 1'b0;
      end else if (slot_i) begin
        unique case (st)
          ST_CMD: begin
            cmd_sr <= cmd_w[7:1];
            bcnt   <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              unique case (cmd_w)
                CMD_READ:   begin rc_o <= 1'b0; st <= ST_READ; end
                CMD_MATCH:  begin rc_o <= 1'b0; st <= ST_MATCH; end
                CMD_SEARCH: begin rc_o <= 1'b0; st <= ST_SEARCH; end
                CMD_SKIP:   begin rc_o <= 1'b0; st <= ST_MEM; mem_sel_o <= 1'b1; end
                CMD_RESUME: begin
                  if (rc_o) begin st <= ST_MEM; mem_sel_o <= 1'b1; end
                  else st <= ST_SINK;
                end
                CMD_ODSKIP: begin
                  rc_o <= 1'b0; od_o <= 1'b1; st <= ST_MEM; mem_sel_o <= 1'b1;
                end
                CMD_ODMTCH: begin
                  rc_o <= 1'b0; od_prev <= od_o; od_o <= 1'b1;
                  od_mtch <= 1'b1; st <= ST_MATCH;
                end
                default: st <= ST_SINK;
              endcase
            end
          end
          ST_READ: begin
            idx <= idx + 1'b1;
            if (last) begin st <= ST_MEM; mem_sel_o <= 1'b1; end
          end
          ST_MATCH: begin
            if (slot_bit_i != id_bit) begin
              st <= ST_SINK;
              if (od_mtch && !od_prev) od_o <= 1'b0;
            end else if (last) begin
              st <= ST_MEM; rc_o <= 1'b1; mem_sel_o <= 1'b1;
            end else idx <= idx + 1'b1;
          end
          ST_SEARCH: begin
            if (ph != 2'd2) ph <= ph + 2'd1;
            else if (slot_bit_i != id_bit) st <= ST_SINK;
            else if (last) begin
              st <= ST_MEM; rc_o <= 1'b1; mem_sel_o <= 1'b1;
            end else begin
              idx <= idx + 1'b1; ph <= 2'd0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SEL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_o |=> !mem_sel_o); // R13
  AST_OWN_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_own_o) |-> mem_sel_o); // R13
  AST_BUS_RST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && id_ready) |=> !mem_own_o); // R13
  AST_RC_RISE_SELECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rc_o) |-> mem_sel_o); // R3
  AST_OD_LONG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && rst_long_i && id_ready) |=> !od_o); // R11
  AST_OD_SHORT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && !rst_long_i && id_ready) |=> $stable(od_o)); // R11
  AST_NO_TX_WHEN_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_own_o |-> !tx_en_o); // R13
endmodule

// File: tb/owrom_net_layer_tb_top.sv
module owrom_net_layer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  FAM = 8'h23;
  localparam logic [47:0] SER = 48'h00A1B2C3D4E5;

  // K_* body kinds
  localparam logic [2:0] K_NONE = 3'd0, K_READ = 3'd1, K_MGOOD = 3'd2,
                         K_MBAD = 3'd3, K_SGOOD = 3'd4, K_SBAD = 3'd5;

  // {long, cmd[7:0], kind[2:0], own, rc, od}
  localparam int NV = 12;
  localparam logic [14:0] TBL [NV] = '{
    {1'b1, 8'h33, K_READ,  1'b1, 1'b0, 1'b0},
    {1'b1, 8'h55, K_MGOOD, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'hA5, K_NONE,  1'b1, 1'b1, 1'b0},
    {1'b1, 8'hCC, K_NONE,  1'b1, 1'b0, 1'b0},
    {1'b1, 8'hA5, K_NONE,  1'b0, 1'b0, 1'b0},
    {1'b1, 8'hF0, K_SGOOD, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'h12, K_NONE,  1'b0, 1'b1, 1'b0},
    {1'b1, 8'hF0, K_SBAD,  1'b0, 1'b0, 1'b0},
    {1'b1, 8'h55, K_MBAD,  1'b0, 1'b0, 1'b0},
    {1'b1, 8'h3C, K_NONE,  1'b1, 1'b0, 1'b1},
    {1'b1, 8'h69, K_MGOOD, 1'b1, 1'b1, 1'b1},
    {1'b1, 8'h69, K_MBAD,  1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_rst = 1'b0, rst_long = 1'b0, slot = 1'b0, slot_bit = 1'b1;
  logic tx_en, tx_bit, od, rc, mem_sel, mem_own, mem_slot, mem_bit;
  int   errors = 0, checks = 0;
  logic done = 1'b0;
  logic [63:0] rid;

  always #(CLK_PERIOD/2) clk = ~clk;

  owrom_net_layer #(.FAMILY(FAM), .SERIAL(SER)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .rst_long_i(rst_long),
    .slot_i(slot), .slot_bit_i(slot_bit), .tx_en_o(tx_en), .tx_bit_o(tx_bit),
    .od_o(od), .rc_o(rc), .mem_sel_o(mem_sel), .mem_own_o(mem_own),
    .mem_slot_o(mem_slot), .mem_bit_o(mem_bit)
  );

  function automatic logic [7:0] crc8_ref(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic f = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_slot(input logic b);
    @(negedge clk); slot = 1'b1; slot_bit = b;
    @(negedge clk); slot = 1'b0; slot_bit = 1'b1;
  endtask

  task automatic do_bus_rst(input logic lng);
    @(negedge clk); bus_rst = 1'b1; rst_long = lng;
    @(negedge clk); bus_rst = 1'b0; rst_long = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) do_slot(v[i]);
  endtask

  task automatic run_body(input logic [2:0] kind, output int bad);
    bad = 0;
    case (kind)
      K_READ:
        for (int i = 0; i < 64; i++) begin
          if (!(tx_en === 1'b1 && tx_bit === rid[i])) bad++;
          do_slot(1'b1);
        end
      K_MGOOD: for (int i = 0; i < 64; i++) do_slot(rid[i]);
      K_MBAD:  for (int i = 0; i < 64; i++) do_slot((i == 20) ? ~rid[i] : rid[i]);
      K_SGOOD, K_SBAD:
        for (int i = 0; i < 64; i++) begin
          if (!(tx_en === 1'b1 && tx_bit === rid[i])) bad++;
          do_slot(1'b1);
          if (!(tx_en === 1'b1 && tx_bit === ~rid[i])) bad++;
          do_slot(1'b1);
          if (kind == K_SBAD && i == 10) begin
            do_slot(~rid[i]);
            for (int k = 0; k < 6; k++) begin
              if (tx_en !== 1'b0) bad++;
              do_slot(1'b1);
            end
            break;
          end
          do_slot(rid[i]);
        end
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    logic sel_seen;
    rid = {crc8_ref({SER, FAM}), SER, FAM};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 od", od, 0); chk("R1 rc", rc, 0); chk("R1 own", mem_own, 0);
    chk("R1 sel", mem_sel, 0); chk("R1 tx_en", tx_en, 0); chk("R1 tx_bit", tx_bit, 1);
    rst_n = 1'b1;
    repeat (80) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [14:0] e = TBL[v];
      string tag;
      case (e[5:3])
        K_READ:  tag = "R2";
        K_MGOOD: tag = (e[13:6] == 8'h69) ? "R10" : "R3";
        K_MBAD:  tag = (e[13:6] == 8'h69) ? "R10" : "R4";
        K_SGOOD: tag = "R5";
        K_SBAD:  tag = "R6";
        default: tag = (e[13:6] == 8'hCC) ? "R7" : (e[13:6] == 8'hA5) ? "R8" :
                       (e[13:6] == 8'h3C) ? "R9" : "R12";
      endcase
      do_bus_rst(e[14]);
      send_byte(e[13:6]);
      if (e[13:6] == 8'h69) chk("R10 od after cmd", od, 1);
      run_body(e[5:3], bad);
      sel_seen = mem_sel;
      chk({tag, " body bits"}, bad, 0);
      chk({tag, " sel"}, sel_seen, e[2]);
      chk({tag, " own"}, mem_own, e[2]);
      chk({tag, " rc"}, rc, e[1]);
      chk({tag, " od"}, od, e[0]);
    end

    // R10 mismatch keeps od when already in overdrive; R11 short keeps, long clears
    do_bus_rst(1'b1); send_byte(8'h3C); chk("R9 od", od, 1);
    do_bus_rst(1'b0); chk("R11 short reset od", od, 1);
    send_byte(8'h69);
    run_body(K_MBAD, bad);
    chk("R10 od kept", od, 1); chk("R10 own", mem_own, 0);
    do_bus_rst(1'b0); chk("R11 short again od", od, 1);
    do_bus_rst(1'b1); chk("R11 long reset od", od, 0);

    // R13 strobe, forwarding, release
    send_byte(8'hCC);
    chk("R13 sel", mem_sel, 1);
    @(negedge clk); chk("R13 sel one cycle", mem_sel, 0);
    @(negedge clk); slot = 1'b1; slot_bit = 1'b0;
    #(CLK_PERIOD/4);
    chk("R13 fwd slot", mem_slot, 1); chk("R13 fwd bit", mem_bit, 0);
    @(negedge clk); slot = 1'b0; slot_bit = 1'b1;
    do_bus_rst(1'b1); chk("R13 release", mem_own, 0);
    @(negedge clk); slot = 1'b1;
    #(CLK_PERIOD/4); chk("R13 no fwd in cmd", mem_slot, 0);
    @(negedge clk); slot = 1'b0;

    // R12 unknown code: later traffic ignored
    do_bus_rst(1'b1); send_byte(8'h00);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      if (tx_en !== 1'b0 || mem_own !== 1'b0) bad++;
      do_slot(i[0]);
    end
    chk("R12 ignored", bad, 0);

    // R4 match bad ignores remaining traffic
    do_bus_rst(1'b1); send_byte(8'h55); run_body(K_MBAD, bad);
    send_byte(8'hCC); chk("R4 stays idle", mem_own, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule